// File: doc/BRIEF.md
# Accumulator Unit with Packed Status Word

This block is an 8-bit accumulator paired with a small arithmetic and shift unit. Each accepted command either replaces the accumulator, combines an operand with it, or moves its bits by one place. The result goes back into the accumulator in the same cycle. Every accepted command also refreshes a set of condition flags: sign, zero, half-carry, carry, overflow and even parity.

The flags are packed into a 16-bit status word. The word also carries hard-wired constant bits, and each flag has a fixed slot. The word is shown so that slot 0 is the most significant output bit, which makes it read left to right when written in hexadecimal. A controller drives one command per cycle with a valid strobe and reads both the accumulator and the status word directly from registers.

Top module: `acc_status_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first accepted command, the accumulator reads 0x00 and the status word reads 0x04C9: all flags are 0 and the constant bits hold their fixed values.
- R2: On a clock edge where `op_valid_i` is low, neither the accumulator nor the status word changes.
- R3: Command 0 (load) writes `operand_i` into the accumulator.
- R4: Command 1 (add) leaves acc+operand modulo 256 in the accumulator. C is the carry out of bit 7. HC is the carry from bit 3 into bit 4. V is the XOR of the carry into bit 7 and the carry out of bit 7.
- R5: Command 2 (subtract) leaves acc-operand modulo 256 in the accumulator. C is the borrow out of bit 7. HC is the borrow out of bit 3. V is the XOR of the borrow into bit 7 and the borrow out of bit 7.
- R6: Command 3 shifts left with a 0 entering bit 0. Command 4 shifts right with a 0 entering bit 7. Command 5 shifts right and keeps bit 7. In each case C receives the bit shifted out.
- R7: Command 6 rotates left and command 7 rotates right by one bit. C receives the bit that wrapped around.
- R8: Every accepted command 0 to 8 sets S to bit 7 of the new accumulator and Z to 1 exactly when it is zero. P is set to the XOR of its eight bits, so the number of ones including P is even.
- R9: Flags that a command does not define keep their previous value. Load and test keep HC, C and V. Shifts and rotates keep HC and V.
- R10: Command 8 (test) leaves the accumulator unchanged and sets S, Z and P from its current value.
- R11: Commands 9 to 15 change neither the accumulator nor the status word.
- R12: Status word output bits, from 15 down to 0, are: S, 0, 0, P, 0, 1, Z, HC, 1, 1, 0, C, 1, 0, V, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid_i | input | 1 | Command strobe; a command is taken on an edge where this is high |
| op_i | input | 4 | Command code (0 to 8 defined, 9 to 15 ignored) |
| operand_i | input | 8 | Operand for load, add and subtract |
| acc_o | output | 8 | Accumulator register |
| psw_o | output | 16 | Packed status word register |

## Verification
The embedded properties assume the command code and operand are known, not X, on every edge where the strobe is high. They also assume the reset release has passed through the internal synchronizer before commands are checked. The stimulus changes inputs only on falling edges and holds reset long enough to cover the synchronizer. It strings the commands into one continuous sequence, so that each expected value depends on the state left by the command before it. That sequence walks through carries and borrows at the nibble and byte boundaries, signed overflow in both directions, and zero results.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  localparam int unsigned OP_W  = 4;
  localparam int unsigned PSW_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SHL  = 4'd3,
    OP_SHR  = 4'd4,
    OP_SAR  = 4'd5,
    OP_ROL  = 4'd6,
    OP_ROR  = 4'd7,
    OP_TEST = 4'd8
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_TEST;

  typedef struct packed {
    logic s;
    logic z;
    logic hc;
    logic c;
    logic v;
    logic p;
  } flags_t;

  // slot index of each flag in the status word (slot 0 drives the MSB)
  localparam int unsigned SLOT_S  = 0;
  localparam int unsigned SLOT_P  = 3;
  localparam int unsigned SLOT_Z  = 6;
  localparam int unsigned SLOT_HC = 7;
  localparam int unsigned SLOT_C  = 11;
  localparam int unsigned SLOT_V  = 14;

  // constant ones, indexed by slot
  localparam logic [PSW_W-1:0] SLOT_ONES = 16'h9320;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            valid_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   opd_i,
  input  flags_t          flags_i,
  output logic [DW-1:0]   res_o,
  output flags_t          flags_o,
  output logic            accept_o
);
  localparam int unsigned HW = DW / 2;

  op_e op_w;
  assign op_w = op_e'(op_i);

  logic [DW:0]   sum_w, dif_w;
  logic [HW:0]   sum_lo_w, dif_lo_w;
  logic [DW-1:0] sum_in_w, dif_in_w;

  assign sum_w    = {1'b0, acc_i} + {1'b0, opd_i};
  assign dif_w    = {1'b0, acc_i} - {1'b0, opd_i};
  assign sum_lo_w = {1'b0, acc_i[HW-1:0]} + {1'b0, opd_i[HW-1:0]};
  assign dif_lo_w = {1'b0, acc_i[HW-1:0]} - {1'b0, opd_i[HW-1:0]};
  assign sum_in_w = {1'b0, acc_i[DW-2:0]} + {1'b0, opd_i[DW-2:0]};
  assign dif_in_w = {1'b0, acc_i[DW-2:0]} - {1'b0, opd_i[DW-2:0]};

  logic known_w;
  assign known_w  = (op_i <= OP_LAST);
  assign accept_o = valid_i && known_w;

  always_comb begin
    res_o   = acc_i;
    flags_o = flags_i;
    unique case (op_w)
      OP_LOAD: res_o = opd_i;
      OP_ADD: begin
        res_o      = sum_w[DW-1:0];
        flags_o.c  = sum_w[DW];
        flags_o.hc = sum_lo_w[HW];
        flags_o.v  = sum_in_w[DW-1] ^ sum_w[DW];
      end
      OP_SUB: begin
        res_o      = dif_w[DW-1:0];
        flags_o.c  = dif_w[DW];
        flags_o.hc = dif_lo_w[HW];
        flags_o.v  = dif_in_w[DW-1] ^ dif_w[DW];
      end
      OP_SHL: begin
        res_o     = {acc_i[DW-2:0], 1'b0};
        flags_o.c = acc_i[DW-1];
      end
      OP_SHR: begin
        res_o     = {1'b0, acc_i[DW-1:1]};
        flags_o.c = acc_i[0];
      end
      OP_SAR: begin
        res_o     = {acc_i[DW-1], acc_i[DW-1:1]};
        flags_o.c = acc_i[0];
      end
      OP_ROL: begin
        res_o     = {acc_i[DW-2:0], acc_i[DW-1]};
        flags_o.c = acc_i[DW-1];
      end
      OP_ROR: begin
        res_o     = {acc_i[0], acc_i[DW-1:1]};
        flags_o.c = acc_i[0];
      end
      OP_TEST: res_o = acc_i;
      default: res_o = acc_i;
    endcase
    flags_o.s = res_o[DW-1];
    flags_o.z = (res_o == '0);
    flags_o.p = ^res_o;
  end
endmodule

// File: rtl/acc_psw_pack.sv
module acc_psw_pack
  import acc_ctrl_pkg::*;
(
  input  flags_t           flags_i,
  output logic [PSW_W-1:0] psw_o
);
  for (genvar slot = 0; slot < PSW_W; slot++) begin : g_slot
    localparam int unsigned OUT_BIT = PSW_W - 1 - slot;
    if (slot == SLOT_S) begin : g_s
      assign psw_o[OUT_BIT] = flags_i.s;
    end else if (slot == SLOT_P) begin : g_p
      assign psw_o[OUT_BIT] = flags_i.p;
    end else if (slot == SLOT_Z) begin : g_z
      assign psw_o[OUT_BIT] = flags_i.z;
    end else if (slot == SLOT_HC) begin : g_hc
      assign psw_o[OUT_BIT] = flags_i.hc;
    end else if (slot == SLOT_C) begin : g_c
      assign psw_o[OUT_BIT] = flags_i.c;
    end else if (slot == SLOT_V) begin : g_v
      assign psw_o[OUT_BIT] = flags_i.v;
    end else begin : g_const
      assign psw_o[OUT_BIT] = SLOT_ONES[slot];
    end
  end
endmodule

// File: rtl/acc_status_unit.sv
module acc_status_unit
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   operand_i,
  output logic [DW-1:0]   acc_o,
  output logic [15:0]     psw_o
);
  logic          rst_sync_n;
  logic [DW-1:0] acc_q, acc_d, res_w;
  flags_t        flags_q, flags_d, flags_w;
  logic          accept_w;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_alu_core #(.DW(DW)) u_core (
    .op_i     (op_i),
    .valid_i  (op_valid_i),
    .acc_i    (acc_q),
    .opd_i    (operand_i),
    .flags_i  (flags_q),
    .res_o    (res_w),
    .flags_o  (flags_w),
    .accept_o (accept_w)
  );

  // next-state selection
  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    if (accept_w) begin
      acc_d   = res_w;
      flags_d = flags_w;
    end
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (accept_w) begin
      acc_q   <= acc_d;
      flags_q <= flags_d;
    end
  end

  acc_psw_pack u_pack (
    .flags_i (flags_q),
    .psw_o   (psw_o)
  );

  assign acc_o = acc_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid_i |=> ($stable(acc_o) && $stable(psw_o)));

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_i == OP_LOAD) |=> (acc_o == $past(operand_i)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_i <= OP_LAST) |=> (psw_o[9] == (acc_o == '0)));

  // R8
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_i <= OP_LAST) |=> (psw_o[12] == ^acc_o));

  // R9
  load_keeps_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && (op_i == OP_LOAD || op_i == OP_TEST))
      |=> ($stable(psw_o[8]) && $stable(psw_o[4]) && $stable(psw_o[1])));

  // R10
  test_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_i == OP_TEST) |=> $stable(acc_o));

  // R11
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_i > OP_LAST) |=> ($stable(acc_o) && $stable(psw_o)));
endmodule

// File: tb/acc_status_unit_tb.sv
`timescale 1ns/1ps
module acc_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid_i;
  logic [3:0]  op_i;
  logic [7:0]  operand_i;
  logic [7:0]  acc_o;
  logic [15:0] psw_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  acc_status_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .operand_i  (operand_i),
    .acc_o      (acc_o),
    .psw_o      (psw_o)
  );

  // {op, operand, expected acc, expected status word}
  localparam int NVEC = 22;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0, 8'hF4, 8'hF4, 16'h94C9},  // R3 load negative value
    {4'd1, 8'hF0, 8'hE4, 16'h84D9},  // R4 -12 + -16, carry out
    {4'd1, 8'h1C, 8'h00, 16'h07D9},  // R4 zero result, HC and C
    {4'd0, 8'h7F, 8'h7F, 16'h15D9},  // R9 load keeps HC and C
    {4'd1, 8'h01, 8'h80, 16'h95CB},  // R4 positive overflow
    {4'd2, 8'h01, 8'h7F, 16'h15CB},  // R5 negative overflow, nibble borrow
    {4'd2, 8'h80, 8'hFF, 16'h84DB},  // R5 borrow out
    {4'd0, 8'h81, 8'h81, 16'h84DB},  // R8 parity of two ones
    {4'd4, 8'h00, 8'h40, 16'h14DB},  // R6 logical right
    {4'd3, 8'hAA, 8'h80, 16'h94CB},  // R6 left, operand unused
    {4'd5, 8'h00, 8'hC0, 16'h84CB},  // R6 sign kept
    {4'd6, 8'h00, 8'h81, 16'h84DB},  // R7 rotate left wraps
    {4'd7, 8'h00, 8'hC0, 16'h84DB},  // R7 rotate right wraps
    {4'd7, 8'h00, 8'h60, 16'h04CB},  // R7 rotate right, zero out
    {4'd3, 8'h00, 8'hC0, 16'h84CB},  // R6 left
    {4'd3, 8'h00, 8'h80, 16'h94DB},  // R6 left, one out
    {4'd3, 8'h00, 8'h00, 16'h06DB},  // R6 left to zero
    {4'd8, 8'h55, 8'h00, 16'h06DB},  // R10 test
    {4'd9, 8'h12, 8'h00, 16'h06DB},  // R11 reserved code
    {4'd2, 8'h01, 8'hFF, 16'h85D9},  // R5 0 - 1
    {4'd1, 8'h01, 8'h00, 16'h07D9},  // R4 wrap to zero
    {4'd2, 8'h00, 8'h00, 16'h06C9}   // R5 zero minus zero
  };

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0:             return "R3 load";
      4'd1:             return "R4 add";
      4'd2:             return "R5 subtract";
      4'd3, 4'd4, 4'd5: return "R6 shift";
      4'd6, 4'd7:       return "R7 rotate";
      4'd8:             return "R10 test";
      default:          return "R11 reserved";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] op, input logic [7:0] opd);
    @(negedge clk);
    op_valid_i = v;
    op_i       = op;
    operand_i  = opd;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    op_valid_i = 1'b0;
    op_i       = 4'd0;
    operand_i  = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 acc at reset", {8'h00, acc_o}, 16'h0000);
    check("R1 status at reset", psw_o, 16'h04C9);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 acc after release", {8'h00, acc_o}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(1'b1, VEC[i][35:32], VEC[i][31:24]);
      check(op_tag(VEC[i][35:32]), {8'h00, acc_o}, {8'h00, VEC[i][23:16]});
      // R8 R9 R12 flags and layout
      check("R12 status word", psw_o, VEC[i][15:0]);
    end

    // R2 strobe low: load must not happen
    apply(1'b0, 4'd0, 8'h33);
    check("R2 acc with strobe low", {8'h00, acc_o}, 16'h0000);
    check("R2 status with strobe low", psw_o, 16'h06C9);

    // R11 highest reserved code
    apply(1'b1, 4'd15, 8'hAA);
    check("R11 acc code 15", {8'h00, acc_o}, 16'h0000);
    check("R11 status code 15", psw_o, 16'h06C9);

    // R1 reset in mid-run clears state
    apply(1'b1, 4'd0, 8'hA5);
    check("R3 load before reset", {8'h00, acc_o}, 16'h00A5);
    #1 rst_n = 1'b0;
    #1;
    check("R1 acc during reset", {8'h00, acc_o}, 16'h0000);
    check("R1 status during reset", psw_o, 16'h04C9);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 test after reset raises Z on the cleared accumulator
    apply(1'b1, 4'd8, 8'hFF);
    check("R10 acc kept by test", {8'h00, acc_o}, 16'h0000);
    check("R10 status after test", psw_o, 16'h06C9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule